// File: doc/BRIEF.md
# MDIO Command Controller

This block runs Clause 22 management transactions on the serial management bus of an Ethernet PHY. Software sees two 16-bit registers. One is the data word. The other is the command word, which holds the operation, the PHY address and the register number. Writing the command word while the controller is idle launches one complete 64-bit frame on MDC/MDIO.

The command word holds a sticky finished flag that software polls. The flag drops while a frame runs and rises again when the controller returns to idle. For a write, software loads the data word before it launches the command. For a read, the 16 bits returned by the PHY replace the data word when the frame ends.

MDC is the system clock divided down. Each MDC level lasts `DIV_HALF` system clocks. MDIO changes only on the falling edge of MDC. Read data is sampled on the rising edge.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, MDC is low, MDIO is not driven, the data word reads 0, and the command word reads 16'h8000 (finished set, all fields 0).
- R2: A command-word write (`reg_sel`=0) accepted while idle clears the finished flag from the next clock and starts a frame.
- R3: Frames are sent MSB first as follows: 32 ones, start bits 01, opcode (10 for a read, 01 for a write), a 5-bit PHY address taken from command bits 12:8, and a 5-bit register number taken from command bits 4:0. Command bit 13 is 1 for a write and 0 for a read.
- R4: MDC idles low and starts low at launch. Each level is held for `DIV_HALF` system clocks. MDIO changes only together with a falling MDC edge.
- R5: In a write frame, the controller drives the turnaround as 1 then 0, followed by the 16 bits that the data word held at launch, MSB first.
- R6: In a read frame, the controller drives the frame through the first turnaround bit. It releases MDIO (`mdio_oe`=0) from the second turnaround bit (frame bit 47, counting from 0) to the end. On each rising MDC edge of the 16 data bits, it samples `mdio_i` MSB first. When the frame ends, the captured value replaces the data word.
- R7: A frame lasts 64 MDC periods (128·`DIV_HALF` clocks). Then the finished flag (command bit 15) is set, MDC is low and MDIO is released.
- R8: While a frame runs, writes to either register are ignored. The frame, the command fields and the data word are unchanged.
- R9: Reading the command word returns finished in bit 15, the operation in bit 13, the PHY address in bits 12:8 and the register number in bits 4:0. All other bits read 0, and the values written to them are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command word, 1 data word |
| reg_wdata | input | 16 | Write data |
| ctrl_rdata | output | 16 | Command word readback with finished flag |
| data_rdata | output | 16 | Data word readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for MDIO (0 = released) |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
The bench goes after four corner cases:
- **Boundaries of the read turnaround.** A controller that releases MDIO one bit early or one bit late fights the PHY or leaves the bus floating. The per-cycle output-enable compare reports either as a mismatch.
- **Read data order and sampling edge.** Reads use patterns with a distinct first bit and last bit. A shift in the wrong direction, or sampling on the falling edge, returns a rotated or mirrored data word.
- **Writes during a running frame.** These are made to both registers. A design that accepts them corrupts the address fields in the readback or the data bits on the wire.
- **Frame length.** The finished flag is timed exactly, so an off-by-one bit count shows up as a late or early flag.

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl #(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] ctrl_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV_HALF - 1);
  localparam logic [5:0] LAST_BIT = 6'd63;
  localparam logic [5:0] RELEASE_BIT = 6'd47;

  logic          busy, op_q, mdc_q;
  logic [4:0]    phy_q, reg_q;
  logic [15:0]   data_q, rx_q;
  logic [63:0]   frame_q;
  logic [5:0]    idx;
  logic [CW-1:0] div_q;

  wire ctrl_wr = reg_wr & ~reg_sel & ~busy;
  wire data_wr = reg_wr & reg_sel & ~busy;
  wire tick    = busy && (div_q == DIV_LAST);
  wire rise    = tick & ~mdc_q;
  wire fall    = tick & mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      op_q    <= 1'b0;
      mdc_q   <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      data_q  <= '0;
      rx_q    <= '0;
      frame_q <= '0;
      idx     <= '0;
      div_q   <= '0;
    end else if (ctrl_wr) begin
      busy    <= 1'b1;
      op_q    <= reg_wdata[13];
      phy_q   <= reg_wdata[12:8];
      reg_q   <= reg_wdata[4:0];
      frame_q <= {32'hFFFF_FFFF, 2'b01, reg_wdata[13] ? 2'b01 : 2'b10,
                  reg_wdata[12:8], reg_wdata[4:0], 2'b10, data_q};
      idx     <= '0;
      div_q   <= '0;
      mdc_q   <= 1'b0;
    end else if (data_wr) begin
      data_q <= reg_wdata;
    end else if (busy) begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) mdc_q <= ~mdc_q;
      if (rise) rx_q <= {rx_q[14:0], mdio_i};
      if (fall) begin
        if (idx == LAST_BIT) begin
          busy <= 1'b0;
          if (!op_q) data_q <= rx_q;
        end else begin
          idx     <= idx + 1'b1;
          frame_q <= {frame_q[62:0], 1'b0};
        end
      end
    end
  end

  assign mdc        = mdc_q;
  assign mdio_o     = frame_q[63];
  assign mdio_oe    = busy & (op_q | (idx < RELEASE_BIT));
  assign ctrl_rdata = {~busy, 1'b0, op_q, phy_q, 3'b000, reg_q};
  assign data_rdata = data_q;

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && !busy) |=> busy);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_mdio_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

  p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(op_q) && $stable(phy_q) && $stable(reg_q)));

  p_frame_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(idx) == LAST_BIT && $past(mdc)));
endmodule

// File: tb/test_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module test_mdio_cmd_ctrl;
  localparam int DH = 2;
  localparam int FRAME_CYC = 128 * DH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0, mdio_i = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] ctrl_rdata, data_rdata;
  logic mdc, mdio_o, mdio_oe;

  mdio_cmd_ctrl #(.DIV_HALF(DH)) i_mdio_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit m_busy = 0, m_op = 0;
  int m_n = 0;
  logic [4:0] m_phy = 0, m_reg = 0;
  logic [15:0] m_data = 0, phy_val = 0;
  logic [63:0] m_frame = 0;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_op = 0; m_phy = 0; m_reg = 0; m_data = 0; m_n = 0;
    end else if (m_busy) begin
      m_n++;
      if (m_n == FRAME_CYC) begin
        m_busy = 0;
        if (!m_op) m_data = phy_val;
      end
    end else if (reg_wr && !reg_sel) begin
      m_busy = 1; m_n = 0;
      m_op = reg_wdata[13]; m_phy = reg_wdata[12:8]; m_reg = reg_wdata[4:0];
      m_frame = '1;
      m_frame[31:0] = {2'b01, (m_op ? 2'b01 : 2'b10), m_phy, m_reg, 2'b10, m_data};
    end else if (reg_wr && reg_sel) begin
      m_data = reg_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int idx;
      bit e_oe;
      idx = (m_n / DH) / 2;
      e_oe = m_busy && (m_op || idx < 47);
      check("R9 command readback", ctrl_rdata, {~m_busy, 1'b0, m_op, m_phy, 3'b000, m_reg});
      check("R6 data word", data_rdata, m_data);
      check("R4 mdc level", {15'd0, mdc}, {15'd0, m_busy ? 1'((m_n / DH) % 2) : 1'b0});
      check("R6 output enable", {15'd0, mdio_oe}, {15'd0, e_oe});
      if (e_oe) begin
        if (idx >= 46) check("R5 mdio bit", {15'd0, mdio_o}, {15'd0, m_frame[63-idx]});
        else check("R3 mdio bit", {15'd0, mdio_o}, {15'd0, m_frame[63-idx]});
      end
      mdio_i = (m_busy && !m_op && idx >= 48) ? phy_val[63-idx] : 1'b1;
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(bit sel, logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wait_done();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset command", ctrl_rdata, 16'h8000);
    check("R1 reset data", data_rdata, 16'h0000);
    check("R1 reset bus", {14'd0, mdc, mdio_oe}, 16'h0000);

    // write frame; junk in bits 15,14,7:5 must be dropped (R9)
    wr(1'b1, 16'hA5C3);
    wr(1'b0, 16'hC000 | 16'h2000 | (16'h1B << 8) | 16'h00E0 | 16'h000E);
    check("R2 finished clears", {15'd0, ctrl_rdata[15]}, 16'h0000);
    check("R9 fields", ctrl_rdata, 16'h3B0E);
    repeat (20) @(negedge clk);
    wr(1'b0, 16'h0000);   // ignored: R8
    wr(1'b1, 16'h1234);   // ignored: R8
    begin
      int k = 0;
      while (ctrl_rdata[15] !== 1'b1 && k < 1000) begin @(negedge clk); k++; end
      check("R7 frame length", 16'(k + 24), 16'(FRAME_CYC));
    end
    check("R8 data kept", data_rdata, 16'hA5C3);

    phy_val = 16'h3C96;
    wr(1'b0, (16'h05 << 8) | 16'h1F);
    wait_done();
    check("R6 read capture", data_rdata, 16'h3C96);

    phy_val = 16'h8001;
    wr(1'b0, (16'h1F << 8) | 16'h00);
    wait_done();
    check("R6 read capture edges", data_rdata, 16'h8001);

    wr(1'b1, 16'h0000);
    wr(1'b0, 16'h2000);
    wait_done();
    check("R5 write zero data kept", data_rdata, 16'h0000);
    check("R7 idle after frame", ctrl_rdata, 16'hA000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule